// File: doc/BRIEF.md
# Framed Byte-Stream Packet Receiver

This block sits behind a UART bit-level receiver and turns its byte stream into fixed-size packets. A packet is ten bytes long: a lead byte 0xEA, six payload bytes, a 16-bit checksum with the upper byte sent first, and a closing byte 0xAE. While idle, the block drops every byte that is not the lead byte. This keeps each payload field at a fixed output slot, however far into a packet the listener joins the stream.

Once a packet is complete, the block compares the received checksum with the sum of the six payload bytes and tests the closing byte. If both match, it updates its payload output and pulses `frame_ok`. If either fails, it pulses `frame_err` and leaves the payload output as it was. A stall of `TMO_CYC` idle cycles in the middle of a packet sends the block back to hunting, so a broken packet cannot absorb the start of the next one.

Top module: `pkt_rx`

## Requirements
- R1: During and straight after reset, `pay_out` is all zeros and `frame_ok` and `frame_err` are low.
- R2: While hunting, every accepted byte other than 0xEA is dropped and causes no pulse. An accepted 0xEA starts a new packet.
- R3: Payload byte k (k = 1..6, counted after the lead byte) appears at `pay_out[8k-1 -: 8]`, so the first payload byte is in bits 7:0.
- R4: The packet is good when the checksum bytes, read as {upper, lower}, equal the 16-bit sum of the six payload bytes and the tenth byte is 0xAE. The edge that accepts the tenth byte of a good packet loads `pay_out` and raises `frame_ok` for exactly one cycle.
- R5: A checksum mismatch raises `frame_err` for exactly one cycle on the edge that accepts the tenth byte. `frame_ok` stays low and `pay_out` keeps its previous value.
- R6: A wrong closing byte behaves like R5: an error pulse and an unchanged `pay_out`.
- R7: After any packet ends, the block hunts again. A tail of a packet received without its lead byte produces no pulse, and the next whole packet is received correctly.
- R8: Inside a packet, 0xEA is plain data and does not restart the count.
- R9: If `TMO_CYC` consecutive cycles pass with no accepted byte while inside a packet, the block returns to hunting without a pulse. A gap of `TMO_CYC-1` cycles does not abort the packet.
- R10: `frame_ok` and `frame_err` are never high in the same cycle, and `pay_out` changes only in a cycle where `frame_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte strobe from the UART receiver |
| in_byte | input | 8 | Received byte, taken when `in_vld` is high |
| pay_out | output | 48 | Six payload bytes of the last good packet |
| frame_ok | output | 1 | One-cycle pulse: good packet delivered |
| frame_err | output | 1 | One-cycle pulse: checksum or closing-byte failure |

## Verification
Both pulses and the payload update are registered. They become visible right after the clock edge that accepts the tenth byte. The bench drives each byte for one cycle starting at a falling edge and samples at the next falling edge, which is just after the accepting edge. It checks the pulses there, and confirms on every earlier byte that no pulse appeared. The timeout is checked at `TMO_CYC-1` and at `TMO_CYC` idle edges after the last accepted byte, the two gap lengths on either side of the limit.

// File: rtl/pkt_rx.sv
module pkt_rx #(
  parameter int          NPAY    = 6,
  parameter logic [7:0]  SOF     = 8'hEA,
  parameter logic [7:0]  EOF     = 8'hAE,
  parameter int          TMO_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [7:0]        in_byte,
  output logic [NPAY*8-1:0] pay_out,
  output logic              frame_ok,
  output logic              frame_err
);
  localparam int IW      = $clog2(NPAY + 4);
  localparam int GW      = $clog2(TMO_CYC + 1);
  localparam int IDX_HI  = NPAY + 1;
  localparam int IDX_LO  = NPAY + 2;

  logic [IW-1:0]     idx;
  logic [15:0]       sum;
  logic [7:0]        hi;
  logic              match;
  logic [GW-1:0]     gap;
  logic [NPAY*8-1:0] shadow;

  wire hunting = (idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      sum       <= '0;
      hi        <= '0;
      match     <= 1'b0;
      gap       <= '0;
      shadow    <= '0;
      pay_out   <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      if (in_vld) begin
        gap <= '0;
        if (hunting) begin
          if (in_byte == SOF) begin
            idx <= IW'(1);
            sum <= '0;
          end
        end else if (idx <= IW'(NPAY)) begin
          for (int k = 0; k < NPAY; k++)
            if (idx == IW'(k + 1)) shadow[k*8 +: 8] <= in_byte;
          sum <= sum + {8'd0, in_byte};
          idx <= idx + IW'(1);
        end else if (idx == IW'(IDX_HI)) begin
          hi  <= in_byte;
          idx <= idx + IW'(1);
        end else if (idx == IW'(IDX_LO)) begin
          match <= ({hi, in_byte} == sum);
          idx   <= idx + IW'(1);
        end else begin
          idx <= '0;
          if (match && in_byte == EOF) begin
            pay_out  <= shadow;
            frame_ok <= 1'b1;
          end else begin
            frame_err <= 1'b1;
          end
        end
      end else if (!hunting) begin
        if (gap == GW'(TMO_CYC - 1)) begin
          idx <= '0;
          gap <= '0;
        end else begin
          gap <= gap + GW'(1);
        end
      end
    end
  end

  // R10
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));

  // R4
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> ($past(in_vld) && $past(in_byte) == EOF));

  // R4
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_vld));

  // R10
  pay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> $stable(pay_out));
endmodule

// File: tb/pkt_rx_tb.sv
module pkt_rx_tb;
  localparam int TMO = 16;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_vld = 0;
  logic [7:0]  in_byte = 0;
  logic [47:0] pay_out;
  logic        frame_ok, frame_err;
  int checks = 0, failures = 0;
  logic [47:0] last_good = '0;

  always #5 clk = ~clk;

  pkt_rx #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .pay_out(pay_out), .frame_ok(frame_ok), .frame_err(frame_err));

  task automatic chk(input string req, input logic [49:0] act, input logic [49:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_vld = 1; in_byte = b;
    @(negedge clk);
    in_vld = 0;
  endtask

  // sends a packet; cks_x / eof_x corrupt checksum or end byte
  task automatic send(input logic [7:0] p [6], input logic [15:0] cks_x,
                      input logic [7:0] eof_b, input string req);
    logic [15:0] s = 0;
    int quiet = 1;
    foreach (p[i]) s += 16'(p[i]);
    s ^= cks_x;
    put(8'hEA);
    if (frame_ok | frame_err) quiet = 0;
    foreach (p[i]) begin put(p[i]); if (frame_ok | frame_err) quiet = 0; end
    put(s[15:8]); if (frame_ok | frame_err) quiet = 0;
    put(s[7:0]);  if (frame_ok | frame_err) quiet = 0;
    put(eof_b);
    chk({req, " no early pulse"}, 50'(quiet), 50'(1));
    if (cks_x == 0 && eof_b == 8'hAE) begin
      last_good = {p[5], p[4], p[3], p[2], p[1], p[0]};
      chk(req, {frame_ok, frame_err, pay_out}, {2'b10, last_good});
    end else begin
      chk(req, {frame_ok, frame_err, pay_out}, {2'b01, last_good});
    end
    @(negedge clk);
    chk({req, " pulse width"}, {frame_ok, frame_err}, 50'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] p [6];
    logic [7:0] g;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", {frame_ok, frame_err, pay_out}, 50'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R1", {frame_ok, frame_err, pay_out}, 50'(0));

    // R3 R4 R2 sweep: arithmetic payloads, leading garbage, short gaps
    for (int f = 0; f < 40; f++) begin
      for (int j = 0; j < f % 4; j++) begin
        g = 8'((f * 13 + j * 7 + 1) & 255);
        if (g == 8'hEA) g = 8'h00;
        put(g);
        chk("R2 garbage", {frame_ok, frame_err}, 50'(0));
      end
      repeat (f % 3) @(negedge clk);
      for (int k = 0; k < 6; k++) p[k] = 8'((f * 53 + k * 29 + 7) & 255);
      send(p, 16'h0, 8'hAE, "R3 R4 sweep");
    end

    // R5 checksum mismatch
    for (int k = 0; k < 6; k++) p[k] = 8'(k + 100);
    send(p, 16'h0100, 8'hAE, "R5 upper cks");
    send(p, 16'h0001, 8'hAE, "R5 lower cks");
    // R6 bad closing byte
    send(p, 16'h0, 8'hAF, "R6");
    send(p, 16'h0, 8'hAE, "R6 recovery");

    // R8 lead byte value inside payload
    p = '{8'hEA, 8'h10, 8'hEA, 8'h20, 8'h30, 8'h40};
    send(p, 16'h0, 8'hAE, "R8");

    // R7 tail of a packet without its lead byte
    foreach (p[i]) p[i] = 8'(i + 1);
    put(8'h04); put(8'h05); put(8'h06); put(8'h00); put(8'h15); put(8'hAE);
    chk("R7 tail quiet", {frame_ok, frame_err, pay_out}, {2'b00, last_good});
    send(p, 16'h0, 8'hAE, "R7 next packet");

    // R9 timeout aborts after TMO idle edges
    put(8'hEA); put(8'h55); put(8'h66); put(8'h77);
    repeat (TMO) @(negedge clk);
    chk("R9 silent abort", {frame_ok, frame_err}, 50'(0));
    for (int k = 0; k < 6; k++) p[k] = 8'(k * 17 + 3);
    send(p, 16'h0, 8'hAE, "R9 after timeout");

    // R9 gap of TMO-1 keeps the packet
    begin
      logic [7:0] q [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
      logic [15:0] s = 16'h0165;
      put(8'hEA); put(q[0]); put(q[1]);
      repeat (TMO - 1) @(negedge clk);
      put(q[2]); put(q[3]); put(q[4]); put(q[5]);
      put(s[15:8]); put(s[7:0]); put(8'hAE);
      last_good = {q[5], q[4], q[3], q[2], q[1], q[0]};
      chk("R9 gap below limit", {frame_ok, frame_err, pay_out}, {2'b10, last_good});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule